// File: doc/BRIEF.md
# Write-Only Secure Key Store

This block keeps a small set of RSA key entries inside the chip. Each entry is a fixed triple: a modulus, one exponent (public, private or a key share, all handled the same way) and a Montgomery conversion factor that depends only on the modulus. Within an entry the three fields sit back to back at consecutive word offsets: modulus first, then exponent, then factor, each field least significant word first.

A controller loads an entry by naming the entry index and a length in words. The store then passively captures 32-bit words from a shared data bus on every cycle the controller marks valid, until the length is reached. Only then does the entry become valid.

The only way out is a word stream toward one exponentiation unit chosen by the controller. That stream uses a start/done handshake, moves one word per cycle while the unit signals ready, and tags each word with the field it belongs to. Nothing in the store can be read back over the host side.

Top module: `secure_key_store`

## Requirements
- R1: After reset every entry is invalid, and `ld_busy`, `ld_done`, `ld_reject`, `rd_valid`, `rd_done` and `rd_err` are 0. `rd_dest` is all zero and `rd_data` is zero.
- R2: During an accepted load, a word is captured only on a cycle with `bus_vld` high. Captured words fill offsets 0, 1, 2 and so on of the target entry, and bus cycles with `bus_vld` low are ignored. `ld_busy` is 1 from the edge after `ld_start` until the last word is captured.
- R3: Accepting a load clears the target entry's valid bit. The bit is set, and `ld_done` pulses one cycle, on the edge that captures the word at offset length-1. A readout of an entry during its load reports an error, and a readout in progress of that entry ends with `rd_err`.
- R4: A load with length 0 or above the entry capacity (`MOD_WORDS+EXP_WORDS+FAC_WORDS`, 12 by default) is rejected. `ld_reject` pulses one cycle after `ld_start`, `ld_busy` stays 0, and the target entry is left invalid.
- R5: A readout request for an invalid entry raises `rd_err` and `rd_done` together for one cycle, one edge after `rd_start`, and emits no word.
- R6: A readout of a valid entry emits exactly the stored length of words, in offset order. It emits one word in each cycle where `rd_ready` is 1 and none while `rd_ready` is 0. `rd_done` pulses on the cycle after the last word.
- R7: `rd_field` tags each emitted word. An offset below `MOD_WORDS` gives 0 (modulus), an offset below `MOD_WORDS+EXP_WORDS` gives 1 (exponent), and any other offset gives 2 (factor).
- R8: While a readout is active, `rd_dest` is one-hot with bit `rd_unit` of the request set. When no readout is active it is all zero.
- R9: `rd_data` is zero on every cycle where `rd_valid` is 0, so key words leave only as valid stream beats.
- R10: Loading one entry leaves the contents and validity of every other entry unchanged.
- R11: `ld_start` is ignored while a load is busy, and `rd_start` is ignored while a readout is active. The running operation keeps its entry, length and destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_start | input | 1 | Begin a load into entry `ld_idx` of `ld_len` words |
| ld_idx | input | $clog2(NUM_ENTRIES) | Target entry of the load |
| ld_len | input | $clog2(CAP+1)+1 | Load length in words |
| bus_vld | input | 1 | Shared bus word is valid this cycle |
| bus_data | input | WORD_W | Shared bus word |
| ld_busy | output | 1 | Load in progress |
| ld_done | output | 1 | One-cycle pulse: load completed, entry valid |
| ld_reject | output | 1 | One-cycle pulse: load length refused |
| rd_start | input | 1 | Begin a readout of entry `rd_idx` |
| rd_idx | input | $clog2(NUM_ENTRIES) | Entry to stream |
| rd_unit | input | $clog2(NUM_UNITS) | Destination exponentiation unit |
| rd_ready | input | 1 | Destination accepts a word this cycle |
| rd_valid | output | 1 | Word on `rd_data` is transferred this cycle |
| rd_data | output | WORD_W | Streamed key word |
| rd_field | output | 2 | Field tag of the streamed word |
| rd_dest | output | NUM_UNITS | One-hot destination select |
| rd_done | output | 1 | One-cycle pulse: readout finished |
| rd_err | output | 1 | One-cycle pulse: readout refused or aborted |

## Verification
Load acceptance (`ld_busy`) and refusal (`ld_reject`) are due one edge after `ld_start`. `ld_done` is due one edge after the final captured bus word. `rd_err` and `rd_done` for an invalid entry are due one edge after `rd_start`. A streamed word is combinational with `rd_ready` in the same cycle, and `rd_done` follows one edge after the last word. The bench therefore drives and samples on the falling clock edge, and waits 1 ns after changing `rd_ready` before it compares `rd_valid`, `rd_data`, `rd_field` and `rd_dest` with values it computes from the entry offset and a per-load seed.

// File: rtl/ks_pkg.sv
package ks_pkg;

    typedef enum logic [1:0] {
        FLD_MOD = 2'd0,
        FLD_EXP = 2'd1,
        FLD_FAC = 2'd2
    } ks_field_e;

    // Which field a word offset inside an entry belongs to.
    function automatic ks_field_e field_of(input int unsigned off,
                                           input int unsigned mod_w,
                                           input int unsigned exp_w);
        if (off < mod_w)         return FLD_MOD;
        if (off < mod_w + exp_w) return FLD_EXP;
        return FLD_FAC;
    endfunction

endpackage

// File: rtl/ks_storage.sv
module ks_storage #(
    parameter int ENTRIES = 4,
    parameter int WORD_W  = 32,
    parameter int CAP     = 12
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [$clog2(ENTRIES)-1:0]   wr_idx,
    input  logic [$clog2(CAP)-1:0]       wr_off,
    input  logic [WORD_W-1:0]            wr_data,
    input  logic                         inv_en,
    input  logic [$clog2(ENTRIES)-1:0]   inv_idx,
    input  logic                         seal_en,
    input  logic [$clog2(ENTRIES)-1:0]   seal_idx,
    input  logic [$clog2(CAP+1)-1:0]     seal_len,
    input  logic [$clog2(ENTRIES)-1:0]   rd_idx,
    input  logic [$clog2(CAP)-1:0]       rd_off,
    output logic [WORD_W-1:0]            rd_word,
    output logic [$clog2(CAP+1)-1:0]     rd_len,
    output logic [ENTRIES-1:0]           ent_vld
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int LEN_W = $clog2(CAP+1);

    logic [WORD_W-1:0] mem [ENTRIES][CAP];
    logic [LEN_W-1:0]  len_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx][wr_off] <= wr_data;
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_vld[e] <= 1'b0;
                len_q[e]   <= '0;
            end else if (inv_en && inv_idx == IDX_W'(e)) begin
                ent_vld[e] <= 1'b0;
            end else if (seal_en && seal_idx == IDX_W'(e)) begin
                ent_vld[e] <= 1'b1;
                len_q[e]   <= seal_len;
            end
        end
    end

    assign rd_word = mem[rd_idx][rd_off];
    assign rd_len  = len_q[rd_idx];

endmodule

// File: rtl/ks_load_ctrl.sv
module ks_load_ctrl #(
    parameter int ENTRIES = 4,
    parameter int WORD_W  = 32,
    parameter int CAP     = 12
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          ld_start,
    input  logic [$clog2(ENTRIES)-1:0]    ld_idx,
    input  logic [$clog2(CAP+1):0]        ld_len,
    input  logic                          bus_vld,
    input  logic [WORD_W-1:0]             bus_data,
    output logic                          ld_busy,
    output logic                          ld_done,
    output logic                          ld_reject,
    output logic                          wr_en,
    output logic [$clog2(ENTRIES)-1:0]    tgt_idx,
    output logic [$clog2(CAP)-1:0]        wr_off,
    output logic [WORD_W-1:0]             wr_data,
    output logic                          inv_en,
    output logic                          seal_en,
    output logic [$clog2(CAP+1)-1:0]      seal_len
);
    localparam int IDX_W   = $clog2(ENTRIES);
    localparam int OFF_W   = $clog2(CAP);
    localparam int LEN_W   = $clog2(CAP+1);
    localparam int LENIN_W = LEN_W + 1;

    logic             busy_q, done_q, rej_q;
    logic [IDX_W-1:0] idx_q;
    logic [LEN_W-1:0] len_q;
    logic [OFF_W-1:0] cnt_q;

    logic start_acc, len_ok, last_word;
    assign start_acc = ld_start && !busy_q;
    assign len_ok    = (ld_len != '0) && (ld_len <= LENIN_W'(CAP));
    assign last_word = (int'(cnt_q) + 1 == int'(len_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            rej_q  <= 1'b0;
            idx_q  <= '0;
            len_q  <= '0;
            cnt_q  <= '0;
        end else begin
            done_q <= 1'b0;
            rej_q  <= 1'b0;
            if (start_acc) begin
                idx_q <= ld_idx;
                cnt_q <= '0;
                if (len_ok) begin
                    busy_q <= 1'b1;
                    len_q  <= LEN_W'(ld_len);
                end else begin
                    rej_q <= 1'b1;
                end
            end else if (busy_q && bus_vld) begin
                cnt_q <= cnt_q + 1'b1;
                if (last_word) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign ld_busy   = busy_q;
    assign ld_done   = done_q;
    assign ld_reject = rej_q;
    assign wr_en     = busy_q && bus_vld;
    assign wr_off    = cnt_q;
    assign wr_data   = bus_data;
    assign inv_en    = start_acc;
    assign tgt_idx   = start_acc ? ld_idx : idx_q;
    assign seal_en   = busy_q && bus_vld && last_word;
    assign seal_len  = len_q;

    // R4
    reject_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
        ld_reject |-> !ld_busy);

    // R11
    load_target_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q)) |-> ($stable(idx_q) && $stable(len_q)));

endmodule

// File: rtl/ks_read_ctrl.sv
module ks_read_ctrl
    import ks_pkg::*;
#(
    parameter int ENTRIES   = 4,
    parameter int WORD_W    = 32,
    parameter int CAP       = 12,
    parameter int MOD_WORDS = 4,
    parameter int EXP_WORDS = 4,
    parameter int UNITS     = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          rd_start,
    input  logic [$clog2(ENTRIES)-1:0]    rd_idx,
    input  logic [$clog2(UNITS)-1:0]      rd_unit,
    input  logic                          rd_ready,
    input  logic [ENTRIES-1:0]            ent_vld,
    input  logic [$clog2(CAP+1)-1:0]      ent_len,
    input  logic [WORD_W-1:0]             ent_word,
    output logic [$clog2(ENTRIES)-1:0]    st_idx,
    output logic [$clog2(CAP)-1:0]        st_off,
    output logic                          rd_valid,
    output logic [WORD_W-1:0]             rd_data,
    output logic [1:0]                    rd_field,
    output logic [UNITS-1:0]              rd_dest,
    output logic                          rd_done,
    output logic                          rd_err
);
    localparam int IDX_W  = $clog2(ENTRIES);
    localparam int OFF_W  = $clog2(CAP);
    localparam int UNIT_W = $clog2(UNITS);

    logic              act_q, done_q, err_q;
    logic [IDX_W-1:0]  idx_q;
    logic [UNIT_W-1:0] unit_q;
    logic [OFF_W-1:0]  off_q;

    logic start_acc, last_word, still_ok;
    assign start_acc = rd_start && !act_q;
    assign last_word = (int'(off_q) + 1 == int'(ent_len));
    assign still_ok  = ent_vld[idx_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            idx_q  <= '0;
            unit_q <= '0;
            off_q  <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (start_acc) begin
                idx_q  <= rd_idx;
                unit_q <= rd_unit;
                off_q  <= '0;
                if (ent_vld[rd_idx]) begin
                    act_q <= 1'b1;
                end else begin
                    err_q  <= 1'b1;
                    done_q <= 1'b1;
                end
            end else if (act_q && !still_ok) begin
                act_q  <= 1'b0;
                err_q  <= 1'b1;
                done_q <= 1'b1;
            end else if (act_q && rd_ready) begin
                off_q <= off_q + 1'b1;
                if (last_word) begin
                    act_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign st_idx   = idx_q;
    assign st_off   = off_q;
    assign rd_valid = act_q && still_ok && rd_ready;
    assign rd_data  = rd_valid ? ent_word : '0;
    assign rd_field = act_q ? 2'(field_of(int'(off_q), MOD_WORDS, EXP_WORDS)) : 2'(FLD_MOD);
    assign rd_done  = done_q;
    assign rd_err   = err_q;

    for (genvar u = 0; u < UNITS; u++) begin : g_dest
        assign rd_dest[u] = act_q && (unit_q == UNIT_W'(u));
    end

    // R8
    dest_onehot0_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rd_dest));

    // R8
    dest_live_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ($countones(rd_dest) == 1));

    // R5
    err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        rd_err |-> rd_done);

    // R6
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        rd_done |-> !rd_valid);

endmodule

// File: rtl/secure_key_store.sv
module secure_key_store #(
    parameter int NUM_ENTRIES = 4,
    parameter int WORD_W      = 32,
    parameter int MOD_WORDS   = 4,
    parameter int EXP_WORDS   = 4,
    parameter int FAC_WORDS   = 4,
    parameter int NUM_UNITS   = 4,
    localparam int CAP     = MOD_WORDS + EXP_WORDS + FAC_WORDS,
    localparam int IDX_W   = $clog2(NUM_ENTRIES),
    localparam int LENIN_W = $clog2(CAP+1) + 1,
    localparam int UNIT_W  = $clog2(NUM_UNITS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ld_start,
    input  logic [IDX_W-1:0]     ld_idx,
    input  logic [LENIN_W-1:0]   ld_len,
    input  logic                 bus_vld,
    input  logic [WORD_W-1:0]    bus_data,
    output logic                 ld_busy,
    output logic                 ld_done,
    output logic                 ld_reject,
    input  logic                 rd_start,
    input  logic [IDX_W-1:0]     rd_idx,
    input  logic [UNIT_W-1:0]    rd_unit,
    input  logic                 rd_ready,
    output logic                 rd_valid,
    output logic [WORD_W-1:0]    rd_data,
    output logic [1:0]           rd_field,
    output logic [NUM_UNITS-1:0] rd_dest,
    output logic                 rd_done,
    output logic                 rd_err
);
    localparam int OFF_W = $clog2(CAP);
    localparam int LEN_W = $clog2(CAP+1);

    logic               wr_en, inv_en, seal_en;
    logic [IDX_W-1:0]   tgt_idx, st_idx;
    logic [OFF_W-1:0]   wr_off, st_off;
    logic [WORD_W-1:0]  wr_data, ent_word;
    logic [LEN_W-1:0]   seal_len, ent_len;
    logic [NUM_ENTRIES-1:0] ent_vld;

    ks_load_ctrl #(.ENTRIES(NUM_ENTRIES), .WORD_W(WORD_W), .CAP(CAP)) u_load (
        .clk(clk), .rst(rst), .ld_start(ld_start), .ld_idx(ld_idx), .ld_len(ld_len),
        .bus_vld(bus_vld), .bus_data(bus_data), .ld_busy(ld_busy), .ld_done(ld_done),
        .ld_reject(ld_reject), .wr_en(wr_en), .tgt_idx(tgt_idx), .wr_off(wr_off),
        .wr_data(wr_data), .inv_en(inv_en), .seal_en(seal_en), .seal_len(seal_len)
    );

    ks_storage #(.ENTRIES(NUM_ENTRIES), .WORD_W(WORD_W), .CAP(CAP)) u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(tgt_idx), .wr_off(wr_off),
        .wr_data(wr_data), .inv_en(inv_en), .inv_idx(tgt_idx), .seal_en(seal_en),
        .seal_idx(tgt_idx), .seal_len(seal_len), .rd_idx(st_idx), .rd_off(st_off),
        .rd_word(ent_word), .rd_len(ent_len), .ent_vld(ent_vld)
    );

    ks_read_ctrl #(.ENTRIES(NUM_ENTRIES), .WORD_W(WORD_W), .CAP(CAP),
                   .MOD_WORDS(MOD_WORDS), .EXP_WORDS(EXP_WORDS), .UNITS(NUM_UNITS)) u_read (
        .clk(clk), .rst(rst), .rd_start(rd_start), .rd_idx(rd_idx), .rd_unit(rd_unit),
        .rd_ready(rd_ready), .ent_vld(ent_vld), .ent_len(ent_len), .ent_word(ent_word),
        .st_idx(st_idx), .st_off(st_off), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_field(rd_field), .rd_dest(rd_dest), .rd_done(rd_done), .rd_err(rd_err)
    );

    // R3
    load_seal_chk: assert property (@(posedge clk) disable iff (rst)
        ld_done |-> ent_vld[tgt_idx]);

    // R3
    no_stream_under_load_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !(ld_busy && tgt_idx == st_idx));

endmodule

// File: tb/secure_key_store_tb_top.sv
module secure_key_store_tb_top;
    localparam int ENT = 4, MW = 4, EW = 4, FW = 4, UNITS = 4;
    localparam int CAP = MW + EW + FW;

    logic clk = 0, rst = 1;
    logic ld_start = 0, bus_vld = 0, rd_start = 0, rd_ready = 0;
    logic [1:0] ld_idx = 0, rd_idx = 0, rd_unit = 0;
    logic [4:0] ld_len = 0;
    logic [31:0] bus_data = 0;
    logic ld_busy, ld_done, ld_reject, rd_valid, rd_done, rd_err;
    logic [31:0] rd_data;
    logic [1:0] rd_field;
    logic [3:0] rd_dest;

    int checks = 0, fails = 0;

    always #5 clk = ~clk;

    secure_key_store dut_i (
        .clk(clk), .rst(rst), .ld_start(ld_start), .ld_idx(ld_idx), .ld_len(ld_len),
        .bus_vld(bus_vld), .bus_data(bus_data), .ld_busy(ld_busy), .ld_done(ld_done),
        .ld_reject(ld_reject), .rd_start(rd_start), .rd_idx(rd_idx), .rd_unit(rd_unit),
        .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data), .rd_field(rd_field),
        .rd_dest(rd_dest), .rd_done(rd_done), .rd_err(rd_err)
    );

    typedef struct packed {
        logic [1:0] idx;
        logic [4:0] len;
        logic [7:0] seed;
        logic       gap;
        logic       stall;
        logic [1:0] unit;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{idx:2'd0, len:5'd12, seed:8'h11, gap:1'b0, stall:1'b0, unit:2'd0},
        '{idx:2'd1, len:5'd12, seed:8'h22, gap:1'b1, stall:1'b1, unit:2'd1},
        '{idx:2'd2, len:5'd5,  seed:8'h33, gap:1'b0, stall:1'b1, unit:2'd2},
        '{idx:2'd3, len:5'd1,  seed:8'h44, gap:1'b1, stall:1'b0, unit:2'd3},
        '{idx:2'd1, len:5'd7,  seed:8'h55, gap:1'b0, stall:1'b0, unit:2'd2},
        '{idx:2'd0, len:5'd12, seed:8'h66, gap:1'b1, stall:1'b1, unit:2'd1}
    };

    function automatic logic [31:0] wv(input logic [7:0] seed, input int k);
        return {seed, 8'(k), 16'hA5C3 ^ 16'(int'(seed) * (k + 3))};
    endfunction

    function automatic logic [1:0] fexp(input int k);
        if (k < MW) return 2'd0;
        if (k < MW + EW) return 2'd1;
        return 2'd2;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_begin(input logic [1:0] idx, input int len);
        ld_start = 1; ld_idx = idx; ld_len = 5'(len);
        @(negedge clk);
        ld_start = 0;
    endtask

    task automatic feed(input logic [7:0] seed, input int from, input int upto, input bit gap);
        for (int k = from; k < upto; k++) begin
            if (gap && (k % 2 == 1)) begin
                bus_vld = 0; bus_data = 32'hDEAD_BEEF;  // R2: ignored cycle
                @(negedge clk);
            end
            bus_vld = 1; bus_data = wv(seed, k);
            @(negedge clk);
        end
        bus_vld = 0; bus_data = 0;
    endtask

    task automatic do_load(input logic [1:0] idx, input int len, input logic [7:0] seed, input bit gap);
        load_begin(idx, len);
        chk(ld_busy == 1 && ld_reject == 0, "R2 busy after start", {31'd0, ld_busy}, 32'd1);
        feed(seed, 0, len, gap);
        chk(ld_done == 1 && ld_busy == 0, "R3 done after last word", {30'd0, ld_done, ld_busy}, 32'd2);
    endtask

    task automatic rd_issue(input logic [1:0] idx, input logic [1:0] unit);
        rd_start = 1; rd_idx = idx; rd_unit = unit;
        @(negedge clk);
        rd_start = 0;
    endtask

    task automatic drain(input logic [7:0] seed, input int len, input bit exp_err,
                         input logic [1:0] unit, input bit stall);
        int cnt = 0;
        for (int cyc = 0; cyc < 300; cyc++) begin
            if (rd_done) break;
            rd_ready = stall ? (cyc % 3 != 2) : 1'b1;
            #1;
            chk(rd_dest == 4'(1 << unit), "R8 dest one-hot", {28'd0, rd_dest}, 32'(1 << unit));
            if (rd_valid) begin
                chk(rd_data == wv(seed, cnt), "R6 word value", rd_data, wv(seed, cnt));
                chk(rd_field == fexp(cnt), "R7 field tag", {30'd0, rd_field}, {30'd0, fexp(cnt)});
                cnt++;
            end else begin
                chk(rd_data == 0, "R9 data zero when idle", rd_data, 32'd0);
                if (!rd_ready) chk(1'b1, "R6 stall", 0, 0);
                else chk(1'b0, "R6 no beat with ready", {31'd0, rd_valid}, 32'd1);
            end
            @(negedge clk);
        end
        rd_ready = 0;
        chk(rd_done == 1, "R6 done pulse", {31'd0, rd_done}, 32'd1);
        chk(rd_err == exp_err, exp_err ? "R5 error flag" : "R6 no error", {31'd0, rd_err}, {31'd0, exp_err});
        chk(cnt == len, "R6 word count", 32'(cnt), 32'(len));
        @(negedge clk);
        chk(rd_dest == 0 && rd_done == 0, "R8 dest idle", {28'd0, rd_dest}, 32'd0);
    endtask

    task automatic expect_err(input logic [1:0] idx, input string req);
        rd_issue(idx, 2'd0);
        chk(rd_err == 1 && rd_done == 1 && rd_valid == 0, req, {29'd0, rd_err, rd_done, rd_valid}, 32'd6);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] es [ENT];
        int el [ENT];
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        chk({ld_busy, ld_done, ld_reject, rd_valid, rd_done, rd_err} == 0, "R1 flags", 0, 0);
        chk(rd_dest == 0 && rd_data == 0, "R1 outputs zero", rd_data, 32'd0);
        for (int e = 0; e < ENT; e++) expect_err(2'(e), "R1 entry invalid after reset");

        // table walk
        for (int v = 0; v < 6; v++) begin
            do_load(VEC[v].idx, int'(VEC[v].len), VEC[v].seed, VEC[v].gap);
            es[VEC[v].idx] = VEC[v].seed; el[VEC[v].idx] = int'(VEC[v].len);
            rd_issue(VEC[v].idx, VEC[v].unit);
            drain(VEC[v].seed, int'(VEC[v].len), 1'b0, VEC[v].unit, VEC[v].stall);
        end

        // R10 independence of entries
        for (int e = 0; e < ENT; e++) begin
            rd_issue(2'(e), 2'(e));
            drain(es[e], el[e], 1'b0, 2'(e), 1'b0);
        end

        // R4 oversize and zero length
        load_begin(2'd2, CAP + 1);
        chk(ld_reject == 1 && ld_busy == 0, "R4 oversize reject", {30'd0, ld_reject, ld_busy}, 32'd2);
        @(negedge clk);
        expect_err(2'd2, "R4 entry left invalid");
        load_begin(2'd3, 0);
        chk(ld_reject == 1 && ld_busy == 0, "R4 zero length reject", {30'd0, ld_reject, ld_busy}, 32'd2);
        @(negedge clk);
        expect_err(2'd3, "R4 entry left invalid");

        // R11 ld_start ignored while busy
        load_begin(2'd0, 3);
        load_begin(2'd1, 20);
        chk(ld_reject == 0 && ld_busy == 1, "R11 second start ignored", {30'd0, ld_reject, ld_busy}, 32'd1);
        feed(8'h77, 0, 3, 1'b0);
        chk(ld_done == 1, "R11 first load completes", {31'd0, ld_done}, 32'd1);
        rd_issue(2'd0, 2'd2);
        drain(8'h77, 3, 1'b0, 2'd2, 1'b0);
        rd_issue(2'd1, 2'd3);
        drain(8'h55, 7, 1'b0, 2'd3, 1'b0);

        // R3 read during load
        load_begin(2'd1, 4);
        feed(8'h88, 0, 2, 1'b0);
        expect_err(2'd1, "R3 read during load");
        feed(8'h88, 2, 4, 1'b0);
        rd_issue(2'd1, 2'd0);
        drain(8'h88, 4, 1'b0, 2'd0, 1'b1);

        // R11 rd_start ignored while active, R6 stall
        rd_issue(2'd0, 2'd1);
        rd_start = 1; rd_idx = 2'd1; rd_unit = 2'd3;
        @(negedge clk);
        rd_start = 0;
        chk(rd_dest == 4'b0010 && rd_valid == 0, "R11 read keeps destination", {28'd0, rd_dest}, 32'd2);
        drain(8'h77, 3, 1'b0, 2'd1, 1'b0);

        // R3 load on an entry being streamed aborts the stream
        rd_issue(2'd0, 2'd2);
        load_begin(2'd0, 2);
        rd_ready = 1; #1;
        chk(rd_valid == 0 && rd_data == 0, "R3 no beat from invalidated entry", rd_data, 32'd0);
        @(negedge clk);
        rd_ready = 0;
        chk(rd_err == 1 && rd_done == 1, "R3 stream aborted", {30'd0, rd_err, rd_done}, 32'd3);
        feed(8'h99, 0, 2, 1'b0);
        rd_issue(2'd0, 2'd2);
        drain(8'h99, 2, 1'b0, 2'd2, 1'b0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule